// File: doc/BRIEF.md
# Dual-Width Integer ALU with Iterative Divider

This block executes one integer arithmetic instruction at a time on 64-bit register operands. The caller presents an 8-bit opcode, the destination register value, the source register value and a signed 32-bit immediate. It pulses `in_valid` while `busy` is low. The block returns the value to be written back to the destination register, with a one-cycle `out_valid` strobe. It sets `op_err` for instructions it cannot execute. Register file access and writeback are left to the surrounding pipeline.

The upper nibble of the opcode names the operation. Bit 3 picks the second operand. The low three bits pick the width: 64-bit or 32-bit. Most operations finish in one cycle. Unsigned division and remainder run through a one-bit-per-cycle restoring divider, and `busy` holds new work off until the result has been delivered. A byte-order conversion operation truncates or byte-reverses the low 16, 32 or 64 bits of the destination.

Top module: `alu_dual_width`

## Requirements
- R1: Opcode bit 3 = 1 takes the source register as the second operand. Bit 3 = 0 takes the 32-bit immediate, sign-extended to 64 bits.
- R2: Opcode bits 2:0 = 111 select 64-bit operation. Any other value selects 32-bit operation. This uses only the low 32 bits of each operand and zero-extends the 32-bit result into the 64-bit output.
- R3: Opcode bits 7:4 select the operation: 0 add, 1 subtract, 2 multiply (low half of product), 4 OR, 5 AND, 10 XOR, 11 move (the second operand), and 8 negate. Negate is the two's complement of the destination, and it ignores the second operand.
- R4: Code 6 shifts left and code 7 shifts right logically. Code 12 shifts right arithmetically. The shift amount is the second operand masked to 5 bits in 32-bit mode and to 6 bits in 64-bit mode.
- R5: Code 3 (unsigned divide) and code 9 (unsigned remainder) take the destination as the dividend. `busy` is high from the cycle after acceptance until the result has been delivered. `out_valid` comes W+1 cycles later than for a single-cycle operation, with W = 64 in 64-bit mode and W = 32 in 32-bit mode. `in_valid` is ignored while `busy` is high.
- R6: A divide by zero returns 0. A remainder by zero returns the dividend at the operating width.
- R7: Code 13 converts byte order and ignores the width bits. The immediate gives the size in bits, which is 16, 32 or 64. With bit 3 = 0 the low size bits of the destination are kept unchanged. With bit 3 = 1 their bytes are reversed. Either way the result is zero-extended.
- R8: A code-13 size other than 16, 32 or 64, or an operation code of 14 or 15, returns 0 with `op_err` = 1. `op_err` is 0 in every other case.
- R9: Single-cycle operations raise `out_valid` for exactly one cycle, in the cycle after acceptance. `out_valid` and `busy` are never high together.
- R10: After a synchronous reset with `rst_n` low, `out_valid`, `busy` and `op_err` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Instruction present; accepted when `busy` is low |
| opcode | input | 8 | Operation [7:4], operand select [3], width class [2:0] |
| dst_val | input | 64 | Destination register value (first operand) |
| src_val | input | 64 | Source register value |
| imm | input | 32 | Signed immediate, or conversion size for code 13 |
| busy | output | 1 | Division in flight or result pending |
| out_valid | output | 1 | Result strobe |
| result | output | 64 | Value for the destination register |
| op_err | output | 1 | Instruction could not be executed |

## Verification
On every cycle, the embedded properties check the following:
- a 32-bit result never carries upper bits;
- an error result is zero;
- an accepted division raises `busy`;
- the divider's last step produces its completion strobe;
- `busy` and `out_valid` never coincide.

The arithmetic values themselves can only be shown by the bench's scenarios. These are:
- sign extension of negative immediates;
- shift masking at amounts 33 and 65;
- arithmetic versus logical right shift;
- divide and remainder by zero;
- the three conversion sizes in both directions.

The same holds for the exact divider latency and for an instruction offered while the divider is busy being dropped.

// File: rtl/alu_dw_pkg.sv
// Package: operation code values shared by the ALU datapath and its top.
// Assumes the operation field is the upper nibble of the opcode.
package alu_dw_pkg;
    localparam logic [3:0] OPC_ADD  = 4'h0;
    localparam logic [3:0] OPC_SUB  = 4'h1;
    localparam logic [3:0] OPC_MUL  = 4'h2;
    localparam logic [3:0] OPC_DIV  = 4'h3;
    localparam logic [3:0] OPC_OR   = 4'h4;
    localparam logic [3:0] OPC_AND  = 4'h5;
    localparam logic [3:0] OPC_LSH  = 4'h6;
    localparam logic [3:0] OPC_RSH  = 4'h7;
    localparam logic [3:0] OPC_NEG  = 4'h8;
    localparam logic [3:0] OPC_MOD  = 4'h9;
    localparam logic [3:0] OPC_XOR  = 4'hA;
    localparam logic [3:0] OPC_MOV  = 4'hB;
    localparam logic [3:0] OPC_ARSH = 4'hC;
    localparam logic [3:0] OPC_END  = 4'hD;
    localparam logic [2:0] CLASS_WIDE = 3'b111;
endpackage

// File: rtl/alu_dw_opsel.sv
// Module: second-operand selector.
// Picks the source register or the sign-extended immediate.
// Assumes IMM_W <= XLEN.
module alu_dw_opsel #(
    parameter int XLEN  = 64,
    parameter int IMM_W = 32
) (
    input  logic             use_reg,
    input  logic [XLEN-1:0]  src_val,
    input  logic [IMM_W-1:0] imm,
    output logic [XLEN-1:0]  operand_b
);
    // Select the register or the sign-extended immediate.
    always_comb begin
        if (use_reg) operand_b = src_val;
        else         operand_b = {{(XLEN-IMM_W){imm[IMM_W-1]}}, imm};
    end
endmodule

// File: rtl/alu_dw_core.sv
// Module: single-cycle ALU datapath.
// Covers every operation except divide and remainder, at full or half width.
// Half-width results are zero-extended.
// Assumes XLEN is a power of two and a multiple of 64 bits' byte layout
// (the conversion sizes 16/32/64 must fit in XLEN).
module alu_dw_core
    import alu_dw_pkg::*;
#(
    parameter int XLEN  = 64,
    parameter int IMM_W = 32
) (
    input  logic [3:0]       code,
    input  logic             swap_be,
    input  logic             wide,
    input  logic [XLEN-1:0]  a,
    input  logic [XLEN-1:0]  b,
    input  logic [IMM_W-1:0] conv_size,
    output logic [XLEN-1:0]  res,
    output logic             err
);
    localparam int HALF   = XLEN / 2;
    localparam int SHW    = $clog2(XLEN);
    localparam int SHN    = $clog2(HALF);
    localparam int NBYTES = XLEN / 8;

    // Keep the low nb bytes, optionally in reversed order; clear the rest.
    function automatic logic [XLEN-1:0] reorder(input logic [XLEN-1:0] v,
                                                input int nb, input logic rev);
        logic [XLEN-1:0] o;
        o = '0;
        for (int i = 0; i < NBYTES; i++) begin
            if (i < nb) begin
                if (rev) o[8*i +: 8] = v[8*(nb-1-i) +: 8];
                else     o[8*i +: 8] = v[8*i +: 8];
            end
        end
        return o;
    endfunction

    logic [HALF-1:0] a_n, b_n, nr;
    logic [XLEN-1:0] wr, conv_res;
    logic            conv_bad, is_conv, bad_code;

    // Byte-order conversion: decode the size and build the reordered value.
    always_comb begin
        conv_bad = 1'b0;
        conv_res = '0;
        case (conv_size)
            IMM_W'(16): conv_res = reorder(a, 2, swap_be);
            IMM_W'(32): conv_res = reorder(a, 4, swap_be);
            IMM_W'(64): conv_res = reorder(a, 8, swap_be);
            default:    conv_bad = 1'b1;
        endcase
    end

    // Compute the full-width and half-width results for the selected code.
    always_comb begin
        a_n      = a[HALF-1:0];
        b_n      = b[HALF-1:0];
        wr       = '0;
        nr       = '0;
        is_conv  = 1'b0;
        bad_code = 1'b0;
        case (code)
            OPC_ADD:  begin wr = a + b;   nr = a_n + b_n; end
            OPC_SUB:  begin wr = a - b;   nr = a_n - b_n; end
            OPC_MUL:  begin wr = a * b;   nr = a_n * b_n; end
            OPC_OR:   begin wr = a | b;   nr = a_n | b_n; end
            OPC_AND:  begin wr = a & b;   nr = a_n & b_n; end
            OPC_XOR:  begin wr = a ^ b;   nr = a_n ^ b_n; end
            OPC_MOV:  begin wr = b;       nr = b_n;       end
            OPC_NEG:  begin wr = '0 - a;  nr = '0 - a_n;  end
            OPC_LSH:  begin
                wr = a << b[SHW-1:0];
                nr = a_n << b_n[SHN-1:0];
            end
            OPC_RSH:  begin
                wr = a >> b[SHW-1:0];
                nr = a_n >> b_n[SHN-1:0];
            end
            OPC_ARSH: begin
                wr = $unsigned($signed(a) >>> b[SHW-1:0]);
                nr = $unsigned($signed(a_n) >>> b_n[SHN-1:0]);
            end
            OPC_END:  is_conv = 1'b1;
            OPC_DIV, OPC_MOD: ;
            default:  bad_code = 1'b1;
        endcase
    end

    // Merge: errors give zero, conversion bypasses the width select.
    always_comb begin
        err = bad_code | (is_conv & conv_bad);
        if (err)          res = '0;
        else if (is_conv) res = conv_res;
        else if (wide)    res = wr;
        else              res = {{HALF{1'b0}}, nr};
    end
endmodule

// File: rtl/alu_dw_divider.sv
// Module: restoring unsigned divider, one quotient bit per cycle.
// Runs XLEN steps at full width and XLEN/2 steps at half width.
// A zero divisor yields all-ones quotient and the dividend as remainder.
// Assumes start is only raised while run and done are both low.
module alu_dw_divider #(
    parameter int XLEN = 64
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start,
    input  logic            wide,
    input  logic [XLEN-1:0] dividend,
    input  logic [XLEN-1:0] divisor,
    output logic            run,
    output logic            done,
    output logic [XLEN-1:0] quot,
    output logic [XLEN-1:0] rem
);
    localparam int HALF = XLEN / 2;
    localparam int CW   = $clog2(XLEN + 1);

    logic [XLEN-1:0] q_r, r_r, d_r, q_nx, r_nx;
    logic [CW-1:0]   cnt;
    logic [XLEN:0]   trial, diff;
    logic            fits;

    // One restoring step: shift in a dividend bit, subtract if it fits.
    always_comb begin
        trial = {r_r, q_r[XLEN-1]};
        diff  = trial - {1'b0, d_r};
        fits  = (trial >= {1'b0, d_r});
        r_nx  = fits ? diff[XLEN-1:0] : trial[XLEN-1:0];
        q_nx  = {q_r[XLEN-2:0], fits};
    end

    // Load on start, then iterate until the step counter expires.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run  <= 1'b0;
            done <= 1'b0;
            cnt  <= '0;
            q_r  <= '0;
            r_r  <= '0;
            d_r  <= '0;
        end else begin
            done <= 1'b0;
            if (start && !run) begin
                q_r <= wide ? dividend : {dividend[HALF-1:0], {HALF{1'b0}}};
                d_r <= wide ? divisor  : {{HALF{1'b0}}, divisor[HALF-1:0]};
                r_r <= '0;
                cnt <= wide ? CW'(XLEN) : CW'(HALF);
                run <= 1'b1;
            end else if (run) begin
                q_r <= q_nx;
                r_r <= r_nx;
                cnt <= cnt - 1'b1;
                if (cnt == CW'(1)) begin
                    run  <= 1'b0;
                    done <= 1'b1;
                end
            end
        end
    end

    assign quot = q_r;
    assign rem  = r_r;

    // R5
    last_step_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run && cnt == CW'(1)) |=> (done && !run));

    // R5
    run_count_live_chk: assert property (@(posedge clk) disable iff (!rst_n)
        run |-> (cnt != '0));
endmodule

// File: rtl/alu_dual_width.sv
// Module: top of the dual-width ALU execution unit.
// Decodes the opcode and feeds the second-operand selector and the
// single-cycle datapath. Divide and remainder go to the iterative divider.
// Results are registered with a one-cycle strobe.
// Assumes the caller only presents work while busy is low (anything else is dropped).
module alu_dual_width
    import alu_dw_pkg::*;
#(
    parameter int XLEN  = 64,
    parameter int IMM_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic [7:0]       opcode,
    input  logic [XLEN-1:0]  dst_val,
    input  logic [XLEN-1:0]  src_val,
    input  logic [IMM_W-1:0] imm,
    output logic             busy,
    output logic             out_valid,
    output logic [XLEN-1:0]  result,
    output logic             op_err
);
    localparam int HALF = XLEN / 2;

    logic [3:0]      code;
    logic            use_reg, wide, accept, is_div, div_start;
    logic [XLEN-1:0] operand_b, core_res, dv_quot, dv_rem;
    logic            core_err, dv_run, dv_done;
    logic            pend_mod, pend_zero, pend_wide;
    logic            out_full;

    // Field decode of the opcode and the acceptance condition.
    always_comb begin
        code      = opcode[7:4];
        use_reg   = opcode[3];
        wide      = (opcode[2:0] == CLASS_WIDE);
        is_div    = (code == OPC_DIV) || (code == OPC_MOD);
        accept    = in_valid && !busy;
        div_start = accept && is_div;
    end

    alu_dw_opsel #(.XLEN(XLEN), .IMM_W(IMM_W)) opsel_i (
        .use_reg   (use_reg),
        .src_val   (src_val),
        .imm       (imm),
        .operand_b (operand_b)
    );

    alu_dw_core #(.XLEN(XLEN), .IMM_W(IMM_W)) core_i (
        .code      (code),
        .swap_be   (use_reg),
        .wide      (wide),
        .a         (dst_val),
        .b         (operand_b),
        .conv_size (imm),
        .res       (core_res),
        .err       (core_err)
    );

    alu_dw_divider #(.XLEN(XLEN)) div_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (div_start),
        .wide     (wide),
        .dividend (dst_val),
        .divisor  (operand_b),
        .run      (dv_run),
        .done     (dv_done),
        .quot     (dv_quot),
        .rem      (dv_rem)
    );

    assign busy = dv_run | dv_done;

    // Remember what kind of division is in flight.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_mod  <= 1'b0;
            pend_zero <= 1'b0;
            pend_wide <= 1'b0;
        end else if (div_start) begin
            pend_mod  <= (code == OPC_MOD);
            pend_wide <= wide;
            pend_zero <= wide ? (operand_b == '0) : (operand_b[HALF-1:0] == '0);
        end
    end

    // Register results from the datapath or the divider, with a strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            op_err    <= 1'b0;
            result    <= '0;
            out_full  <= 1'b0;
        end else begin
            out_valid <= 1'b0;
            op_err    <= 1'b0;
            if (accept && !is_div) begin
                out_valid <= 1'b1;
                op_err    <= core_err;
                result    <= core_res;
                out_full  <= wide || (code == OPC_END);
            end else if (dv_done) begin
                out_valid <= 1'b1;
                out_full  <= pend_wide;
                if (pend_mod)
                    result <= pend_wide ? dv_rem : {{HALF{1'b0}}, dv_rem[HALF-1:0]};
                else if (pend_zero)
                    result <= '0;
                else
                    result <= pend_wide ? dv_quot : {{HALF{1'b0}}, dv_quot[HALF-1:0]};
            end
        end
    end

    // R2
    half_zero_ext_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_full) |-> (result[XLEN-1:HALF] == '0));

    // R8
    err_result_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && op_err) |-> (result == '0));

    // R8
    err_only_with_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        op_err |-> out_valid);

    // R5
    div_goes_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        div_start |=> busy);

    // R9
    busy_valid_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(busy && out_valid));
endmodule

// File: tb/alu_dual_width_tb_top.sv
// Bench: behavioural reference model compared against the unit on every cycle.
module alu_dual_width_tb_top;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [7:0]  opcode = '0;
    logic [63:0] dst_val = '0, src_val = '0;
    logic [31:0] imm = '0;
    logic        busy, out_valid, op_err;
    logic [63:0] result;

    int checks = 0;
    int fails  = 0;
    bit done_flag = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    alu_dual_width dut_i (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .opcode(opcode),
        .dst_val(dst_val), .src_val(src_val), .imm(imm),
        .busy(busy), .out_valid(out_valid), .result(result), .op_err(op_err)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // Reference model written from the requirements.
    function automatic void ref_model(input logic [7:0] opc, input logic [63:0] d,
        input logic [63:0] s, input logic [31:0] k,
        output logic [63:0] res, output bit err, output int lat);
        longint unsigned b, a, r;
        int unsigned a32, b32, r32;
        int nb;
        bit w;
        w   = (opc[2:0] == 3'b111);
        b   = opc[3] ? s : {{32{k[31]}}, k};
        a   = d;
        a32 = d[31:0];
        b32 = b[31:0];
        err = 0; lat = 1; r = 0; r32 = 0;
        case (opc[7:4])
            4'h0: begin r = a + b;  r32 = a32 + b32; end
            4'h1: begin r = a - b;  r32 = a32 - b32; end
            4'h2: begin r = a * b;  r32 = a32 * b32; end
            4'h4: begin r = a | b;  r32 = a32 | b32; end
            4'h5: begin r = a & b;  r32 = a32 & b32; end
            4'hA: begin r = a ^ b;  r32 = a32 ^ b32; end
            4'hB: begin r = b;      r32 = b32; end
            4'h8: begin r = -a;     r32 = -a32; end
            4'h6: begin r = a << (b % 64); r32 = a32 << (b32 % 32); end
            4'h7: begin r = a >> (b % 64); r32 = a32 >> (b32 % 32); end
            4'hC: begin
                r   = longint'($signed(a) >>> (b % 64));
                r32 = int'($signed(a32) >>> (b32 % 32));
            end
            4'h3: begin
                lat = w ? 66 : 34;
                r   = (b == 0) ? 0 : a / b;
                r32 = (b32 == 0) ? 0 : a32 / b32;
            end
            4'h9: begin
                lat = w ? 66 : 34;
                r   = (b == 0) ? a : a % b;
                r32 = (b32 == 0) ? a32 : a32 % b32;
            end
            4'hD: begin
                nb = (k == 16) ? 2 : (k == 32) ? 4 : (k == 64) ? 8 : 0;
                if (nb == 0) err = 1;
                r = 0;
                for (int i = 0; i < nb; i++) begin
                    if (opc[3]) r[8*i +: 8] = d[8*(nb-1-i) +: 8];
                    else        r[8*i +: 8] = d[8*i +: 8];
                end
                res = err ? 64'd0 : r;
                return;
            end
            default: err = 1;
        endcase
        if (err)    res = 0;
        else if (w) res = r;
        else        res = {32'd0, r32};
    endfunction

    // Issue one instruction; compare out_valid each cycle until the expected one.
    // If poke is set, an ADD is offered while the divider is busy.
    task automatic run_op(input logic [7:0] opc, input logic [63:0] d,
        input logic [63:0] s, input logic [31:0] k, input string req, input bit poke);
        logic [63:0] er;
        bit ee;
        int lat;
        bit timing_ok;
        ref_model(opc, d, s, k, er, ee, lat);
        @(negedge clk);
        while (busy) @(negedge clk);
        opcode = opc; dst_val = d; src_val = s; imm = k; in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        timing_ok = 1;
        for (int c = 1; c <= lat; c++) begin
            if (c > 1) @(negedge clk);
            if (poke && c == 5) begin
                opcode = 8'h07; dst_val = 64'd1; imm = 32'd1; in_valid = 1'b1;
            end
            if (poke && c == 6) in_valid = 1'b0;
            if (out_valid !== (c == lat)) timing_ok = 0;
        end
        check(timing_ok, req, "out_valid timing", {63'd0, out_valid}, 64'd1);
        check(result === er, req, "result", result, er);
        check(op_err === ee, "R8", "op_err", {63'd0, op_err}, {63'd0, ee});
        if (poke) begin
            bit quiet = 1;
            for (int c = 0; c < 4; c++) begin
                @(negedge clk);
                if (out_valid !== 1'b0) quiet = 0;
            end
            check(quiet, "R5", "input while busy dropped", {63'd0, !quiet}, 64'd0);
        end
    endtask

    task automatic summary();
        $display("  %0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done_flag) begin
            checks++; fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            summary();
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R10 reset state
        check(!out_valid && !busy && !op_err, "R10", "reset outputs",
              {61'd0, out_valid, busy, op_err}, 64'd0);
        rst_n = 1'b1;
        // R1 immediate sign extension, 64-bit add
        run_op(8'h07, 64'h0000_0001_0000_0010, 64'd0, 32'hFFFF_FFF0, "R1", 0);
        // R1 register operand ignores immediate
        run_op(8'h0F, 64'd5, 64'h1234_0000_0000_0003, 32'h7777, "R1", 0);
        // R2 32-bit add wraps, zero-extended
        run_op(8'h0C, 64'hAAAA_AAAA_FFFF_FFFF, 64'h5555_5555_0000_0002, 32'd0, "R2", 0);
        run_op(8'h04, 64'hFFFF_FFFF_0000_0000, 64'd0, 32'h8000_0000, "R2", 0);
        // R3 arithmetic and logic codes
        run_op(8'h1F, 64'd10, 64'd20, 32'd0, "R3", 0);
        run_op(8'h2F, 64'h1_0000_0003, 64'h2_0000_0005, 32'd0, "R3", 0);
        run_op(8'h2C, 64'h1_0000_0003, 64'h2_8000_0005, 32'd0, "R3", 0);
        run_op(8'h4F, 64'hF0F0, 64'h0F0F_0000_0000_0000, 32'd0, "R3", 0);
        run_op(8'h57, 64'hFFFF_FFFF_FFFF_FFFF, 64'd0, 32'h8000_00FF, "R3", 0);
        run_op(8'hAC, 64'hFFFF_0000_1234_5678, 64'h0000_0000_FFFF_FFFF, 32'd0, "R3", 0);
        run_op(8'hB4, 64'hDEAD, 64'd0, 32'hFFFF_FFFE, "R3", 0);
        run_op(8'hBC, 64'hDEAD, 64'hFFFF_FFFF_8765_4321, 32'd0, "R3", 0);
        run_op(8'h87, 64'd1, 64'd99, 32'd7, "R3", 0);
        run_op(8'h84, 64'd1, 64'd99, 32'd7, "R3", 0);
        // R4 shift masking and arithmetic vs logical
        run_op(8'h64, 64'h0000_0000_4000_0001, 64'd0, 32'd33, "R4", 0);
        run_op(8'h67, 64'h8000_0000_0000_0001, 64'd0, 32'd65, "R4", 0);
        run_op(8'h74, 64'h0000_0000_8000_0000, 64'd0, 32'd4, "R4", 0);
        run_op(8'hC4, 64'h0000_0000_8000_0000, 64'd0, 32'd4, "R4", 0);
        run_op(8'hCF, 64'h8000_0000_0000_0000, 64'd63, 32'd0, "R4", 0);
        run_op(8'h7F, 64'h8000_0000_0000_0000, 64'd63, 32'd0, "R4", 0);
        // R5 divide and remainder, both widths
        run_op(8'h3F, 64'hFFFF_FFFF_FFFF_FFFF, 64'd7, 32'd0, "R5", 0);
        run_op(8'h9F, 64'h1234_5678_9ABC_DEF0, 64'h1_0000_0001, 32'd0, "R5", 0);
        run_op(8'h34, 64'h1_0000_0064, 64'd0, 32'd7, "R5", 1);
        run_op(8'h94, 64'h1_0000_0064, 64'd0, 32'd7, "R5", 0);
        run_op(8'h37, 64'd100, 64'd0, 32'hFFFF_FFFF, "R5", 0);
        // R6 zero divisors
        run_op(8'h3F, 64'd12345, 64'd0, 32'd0, "R6", 0);
        run_op(8'h9F, 64'hCAFE_F00D_1234_5678, 64'd0, 32'd0, "R6", 0);
        run_op(8'h9C, 64'hCAFE_F00D_1234_5678, 64'hFFFF_FFFF_0000_0000, 32'd0, "R6", 0);
        // R7 byte-order conversion
        run_op(8'hD4, 64'h1122_3344_5566_7788, 64'd0, 32'd16, "R7", 0);
        run_op(8'hDC, 64'h1122_3344_5566_7788, 64'd0, 32'd16, "R7", 0);
        run_op(8'hDC, 64'h1122_3344_5566_7788, 64'd0, 32'd32, "R7", 0);
        run_op(8'hDC, 64'h1122_3344_5566_7788, 64'd0, 32'd64, "R7", 0);
        run_op(8'hD4, 64'h1122_3344_5566_7788, 64'd0, 32'd64, "R7", 0);
        // R8 illegal size and unused codes
        run_op(8'hDC, 64'h1122_3344_5566_7788, 64'd0, 32'd8, "R8", 0);
        run_op(8'hEF, 64'd1, 64'd2, 32'd0, "R8", 0);
        run_op(8'hF4, 64'd1, 64'd2, 32'd3, "R8", 0);
        // R9 back-to-back single-cycle ops: exactly one strobe each
        run_op(8'h07, 64'd1, 64'd0, 32'd1, "R9", 0);
        @(negedge clk);
        check(!out_valid, "R9", "strobe is one cycle", {63'd0, out_valid}, 64'd0);
        done_flag = 1;
        summary();
    end
endmodule